// File: doc/BRIEF.md
# Plug-in Module Window Decoder with Byte-Lane Swap

This block sits between a host local bus and four plug-in module slots. A host access carries a window code, an address, a size flag (byte or halfword), a write flag and write data. The block turns this into a one-hot slot strobe, a space code (I/O, ID, interrupt or memory) and an offset inside that space. The module side is a plain strobe-and-data port. Modules return read data in the strobe cycle, and the block registers that data as the host response one clock later.

Three host windows are decoded. The small window carries the I/O, ID and interrupt spaces of every slot. The 16-bit memory window spans 8 MiB per slot. The 8-bit memory window spans 4 MiB per slot and accepts byte accesses only. The small window and the 16-bit memory window can each be set to big-endian. In that mode a byte access inverts address bit 0 before decoding, and a halfword access exchanges the two data bytes in both directions.

The endian bits are held in a byte-wide configuration space. A third endian bit belongs to the register window. That bit is only stored and read back here. An access that decodes to a slot with no module fitted, or to a slot number beyond the fitted range, raises no strobe. A read of that kind returns zero.

Top module: `slot_window_decoder`

## Requirements
- R1: After reset, rspValid is 0, no modStrobe bit is set, and all three endian bits read back as 0.
- R2: Window code 0 is the small window. The slot is address >> 8, and values of 4 or more miss. The space field is address[7:6]. Values 0 and 1 give modSpace 0 (I/O) with offset address[6:0]. Value 2 gives modSpace 1 (ID) and value 3 gives modSpace 2 (interrupt), each with offset address[5:0].
- R3: Window code 1 is the 16-bit memory window. The slot is address[24:23], the offset is address[22:0] and modSpace is 3 (memory).
- R4: Window code 2 is the 8-bit memory window. The slot is address >> 22, and values of 4 or more miss. The offset is address[21:0] and modSpace is 3. A halfword access here raises no strobe and reads 0. No endian adjustment is ever applied. Read data is {8'h00, modRData[7:0]}.
- R5: A byte access (reqHalf 0) in a big-endian window (code 0 or 1) inverts address bit 0 before the slot, space and offset are decoded.
- R6: A halfword access in a big-endian window exchanges the bytes of reqWData on modWData, and exchanges the bytes of modRData on rspData.
- R7: In the configuration space, bit 0 of byte 0x2B is the register-window endian bit, bit 0 of byte 0x2F is the small-window bit and bit 0 of byte 0x33 is the 16-bit memory window bit. Each is written from cfgWData[0] and reads as {7'b0, bit}. Every other byte reads 0x00, and writes to it change nothing.
- R8: An access to a slot whose slotPresent bit is 0, to an out-of-range slot, or with window code 3 raises no strobe. A read of that kind returns rspData 0.
- R9: modStrobe has at most one bit set. A bit is set only in a cycle where reqValid is high, and that bit selects the decoded slot. modWrite, modHalf, modSpace, modOffset and modWData are valid in that cycle.
- R10: A read request gives rspValid high in the next cycle with the response on rspData. A write request gives no rspValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrite | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 7 | Configuration byte address |
| cfgWData | input | 8 | Configuration write data |
| cfgRData | output | 8 | Configuration read data (combinational) |
| reqValid | input | 1 | Host access request, one cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWindow | input | 2 | 0 small window, 1 16-bit memory, 2 8-bit memory, 3 none |
| reqHalf | input | 1 | 1 = halfword, 0 = byte |
| reqAddr | input | 25 | Host address within the window |
| reqWData | input | 16 | Host write data |
| slotPresent | input | 4 | Module fitted, one bit per slot |
| modStrobe | output | 4 | One-hot slot strobe |
| modWrite | output | 1 | Write flag to modules |
| modHalf | output | 1 | Size flag to modules |
| modSpace | output | 2 | 0 I/O, 1 ID, 2 interrupt, 3 memory |
| modOffset | output | 23 | Offset inside the space |
| modWData | output | 16 | Lane-adjusted write data |
| modRData | input | 16 | Module read data in the strobe cycle |
| rspValid | output | 1 | Read response valid |
| rspData | output | 16 | Lane-adjusted read response |

## Verification
On every cycle, the assertions check that the strobe is one-hot or idle and appears only alongside a request. They also check that it never reaches an empty slot or a refused access, that each read gets a response in the next cycle and nothing else does, and that missed reads return zero. Only the bench scenarios can show the exact slot, space and offset chosen for each window and address. The same holds for the address-bit inversion and byte exchange under each endian setting, the 8-bit window ignoring the endian setting, and configuration bytes outside the three endian bytes ignoring writes.

// File: rtl/sdec_pkg.sv
package sdec_pkg;
  typedef enum logic [1:0] {
    SP_IO  = 2'd0,
    SP_ID  = 2'd1,
    SP_INT = 2'd2,
    SP_MEM = 2'd3
  } space_t;

  // Lane decisions made by control, applied by the datapath
  typedef struct packed {
    logic flipLow;     // invert address bit 0
    logic swapLanes;   // exchange data bytes
    logic narrowLane;  // 8-bit window: upper read byte forced to zero
    logic refuse;      // access never reaches a module
  } laneCtl_t;

  function automatic logic [15:0] swapBytes(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction
endpackage

// File: rtl/sdec_ctrl.sv
module sdec_ctrl
  import sdec_pkg::*;
#(
  parameter int CFG_AW      = 7,
  parameter int ENDIAN_BASE = 'h2B,
  parameter int ENDIAN_STEP = 4,
  parameter int N_ENDIAN    = 3,
  parameter logic [7:0] CFG_FILL = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [7:0]        cfgWData,
  output logic [7:0]        cfgRData,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqWindow,
  input  logic              reqHalf,
  output laneCtl_t          laneCtl,
  output logic              rspValid
);
  // index 0: register window, 1: small window, 2: 16-bit memory window
  logic [N_ENDIAN-1:0] bigEnd;
  logic [N_ENDIAN-1:0] cfgHit;

  for (genvar g = 0; g < N_ENDIAN; g++) begin : gEndian
    localparam logic [CFG_AW-1:0] BYTE_ADDR = CFG_AW'(ENDIAN_BASE + g * ENDIAN_STEP);
    assign cfgHit[g] = (cfgAddr == BYTE_ADDR);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bigEnd[g] <= 1'b0;
      else if (cfgWrite && cfgHit[g]) bigEnd[g] <= cfgWData[0];
    end
  end

  always_comb begin
    cfgRData = CFG_FILL;
    for (int i = 0; i < N_ENDIAN; i++) begin
      if (cfgHit[i]) cfgRData = {7'b0, bigEnd[i]};
    end
  end

  logic winBig;
  always_comb begin
    case (reqWindow)
      2'd0:    winBig = bigEnd[1];
      2'd1:    winBig = bigEnd[2];
      default: winBig = 1'b0;
    endcase
    laneCtl.flipLow    = winBig && !reqHalf;
    laneCtl.swapLanes  = winBig && reqHalf;
    laneCtl.narrowLane = (reqWindow == 2'd2);
    laneCtl.refuse     = (reqWindow == 2'd3) || ((reqWindow == 2'd2) && reqHalf);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid && !reqWrite;
  end
endmodule

// File: rtl/sdec_datapath.sv
module sdec_datapath
  import sdec_pkg::*;
#(
  parameter int ADDR_W       = 25,
  parameter int DATA_W       = 16,
  parameter int N_SLOTS      = 4,
  parameter int IO_SLOT_LSB  = 8,
  parameter int M16_SLOT_LSB = 23,
  parameter int M8_SLOT_LSB  = 22,
  parameter int IO_OFF_W     = 7,
  parameter int SMALL_OFF_W  = 6,
  localparam int OFF_W       = M16_SLOT_LSB
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [1:0]         reqWindow,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqWData,
  input  laneCtl_t           laneCtl,
  input  logic [N_SLOTS-1:0] slotPresent,
  input  logic [DATA_W-1:0]  modRData,
  output logic [N_SLOTS-1:0] modStrobe,
  output logic [1:0]         modSpace,
  output logic [OFF_W-1:0]   modOffset,
  output logic [DATA_W-1:0]  modWData,
  output logic [DATA_W-1:0]  rspData
);
  localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

  logic [ADDR_W-1:0] adjAddr;
  logic [ADDR_W-1:0] slotWide;
  logic [SLOT_W-1:0] slotIdx;
  space_t            space;
  logic              inRange;
  logic              hit;

  assign adjAddr = {reqAddr[ADDR_W-1:1], reqAddr[0] ^ laneCtl.flipLow};

  always_comb begin
    slotWide  = '0;
    space     = SP_MEM;
    modOffset = '0;
    case (reqWindow)
      2'd0: begin
        slotWide = adjAddr >> IO_SLOT_LSB;
        case (adjAddr[7:6])
          2'd2:    space = SP_ID;
          2'd3:    space = SP_INT;
          default: space = SP_IO;
        endcase
        if (space == SP_IO) modOffset = OFF_W'(adjAddr[IO_OFF_W-1:0]);
        else                modOffset = OFF_W'(adjAddr[SMALL_OFF_W-1:0]);
      end
      2'd1: begin
        slotWide  = adjAddr >> M16_SLOT_LSB;
        modOffset = adjAddr[OFF_W-1:0];
      end
      2'd2: begin
        slotWide  = adjAddr >> M8_SLOT_LSB;
        modOffset = OFF_W'(adjAddr[M8_SLOT_LSB-1:0]);
      end
      default: slotWide = '0;
    endcase
  end

  assign slotIdx  = slotWide[SLOT_W-1:0];
  assign inRange  = (slotWide < ADDR_W'(N_SLOTS));
  assign hit      = reqValid && !laneCtl.refuse && inRange && slotPresent[slotIdx];
  assign modSpace = space;
  assign modWData = laneCtl.swapLanes ? swapBytes(reqWData) : reqWData;

  for (genvar s = 0; s < N_SLOTS; s++) begin : gStrobe
    assign modStrobe[s] = hit && (slotIdx == SLOT_W'(s));
  end

  logic [DATA_W-1:0] laneData;
  always_comb begin
    if (laneCtl.swapLanes)       laneData = swapBytes(modRData);
    else if (laneCtl.narrowLane) laneData = {8'h00, modRData[7:0]};
    else                         laneData = modRData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspData <= '0;
    else if (reqValid && !reqWrite) rspData <= hit ? laneData : '0;
  end
endmodule

// File: rtl/slot_window_decoder.sv
module slot_window_decoder
  import sdec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrite,
  input  logic [6:0]  cfgAddr,
  input  logic [7:0]  cfgWData,
  output logic [7:0]  cfgRData,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [1:0]  reqWindow,
  input  logic        reqHalf,
  input  logic [24:0] reqAddr,
  input  logic [15:0] reqWData,
  input  logic [3:0]  slotPresent,
  output logic [3:0]  modStrobe,
  output logic        modWrite,
  output logic        modHalf,
  output logic [1:0]  modSpace,
  output logic [22:0] modOffset,
  output logic [15:0] modWData,
  input  logic [15:0] modRData,
  output logic        rspValid,
  output logic [15:0] rspData
);
  laneCtl_t laneCtl;

  sdec_ctrl #(.CFG_AW(7)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgWrite(cfgWrite), .cfgAddr(cfgAddr), .cfgWData(cfgWData), .cfgRData(cfgRData),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqWindow(reqWindow), .reqHalf(reqHalf),
    .laneCtl(laneCtl), .rspValid(rspValid)
  );

  sdec_datapath #(.ADDR_W(25), .DATA_W(16), .N_SLOTS(4)) uData (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqWindow(reqWindow),
    .reqAddr(reqAddr), .reqWData(reqWData), .laneCtl(laneCtl),
    .slotPresent(slotPresent), .modRData(modRData),
    .modStrobe(modStrobe), .modSpace(modSpace), .modOffset(modOffset),
    .modWData(modWData), .rspData(rspData)
  );

  assign modWrite = reqWrite;
  assign modHalf  = reqHalf;
endmodule

// File: rtl/sdec_checker.sv
module sdec_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [1:0]  reqWindow,
  input logic        reqHalf,
  input logic [3:0]  slotPresent,
  input logic [3:0]  modStrobe,
  input logic        rspValid,
  input logic [15:0] rspData
);
  p_onehot_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(modStrobe));

  p_strobe_needs_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modStrobe != 4'b0) |-> reqValid);

  p_absent_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modStrobe & ~slotPresent) == 4'b0);

  p_no_window_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqWindow == 2'd3) |-> (modStrobe == 4'b0));

  p_narrow_refuse_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWindow == 2'd2 && reqHalf) |-> (modStrobe == 4'b0));

  p_rsp_follows_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> rspValid);

  p_rsp_only_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && !reqWrite));

  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && modStrobe == 4'b0) |=> (rspData == 16'h0));
endmodule

bind slot_window_decoder sdec_checker uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqWindow(reqWindow), .reqHalf(reqHalf), .slotPresent(slotPresent),
  .modStrobe(modStrobe), .rspValid(rspValid), .rspData(rspData)
);

// File: tb/slot_window_decoder_test.sv
module slot_window_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 50000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [6:0]  cfgAddr = '0;
  logic [7:0]  cfgWData = '0;
  logic [7:0]  cfgRData;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqWindow = '0;
  logic        reqHalf = 1'b0;
  logic [24:0] reqAddr = '0;
  logic [15:0] reqWData = '0;
  logic [3:0]  slotPresent = 4'hF;
  logic [3:0]  modStrobe;
  logic        modWrite, modHalf;
  logic [1:0]  modSpace;
  logic [22:0] modOffset;
  logic [15:0] modWData;
  logic [15:0] modRData;
  logic        rspValid;
  logic [15:0] rspData;

  int nChecks = 0;
  int nFails = 0;
  bit ioBig = 0;
  bit memBig = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_window_decoder uut (.*);

  function automatic logic [15:0] modelData(input int slot, input logic [1:0] sp,
                                            input logic [22:0] off);
    return {2'(slot), sp, off[11:0] ^ 12'h5A3};
  endfunction

  // Module model: data depends on which slot is strobed and where
  always_comb begin
    modRData = 16'hBAD0;
    for (int i = 0; i < 4; i++)
      if (modStrobe[i]) modRData = modelData(i, modSpace, modOffset);
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfgWr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrite = 1'b1; cfgAddr = a; cfgWData = d;
    @(negedge clk);
    cfgWrite = 1'b0;
    if (a == 7'h2F) ioBig = d[0];
    if (a == 7'h33) memBig = d[0];
  endtask

  task automatic cfgRd(input logic [6:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cfgAddr = a;
    #1;
    check(tag, 32'(cfgRData), 32'(exp));
  endtask

  task automatic access(input logic [1:0] win, input logic [24:0] addr, input bit half,
                        input bit wr, input logic [15:0] wd, input string tag);
    bit big, ok, hit;
    logic [24:0] a, s;
    logic [1:0] sp;
    logic [22:0] off;
    logic [15:0] raw, expR, expW;
    big = (win == 2'd0) ? ioBig : (win == 2'd1) ? memBig : 1'b0;
    a = addr;
    if (big && !half) a[0] = ~a[0];
    ok = 1; s = '0; sp = 2'd3; off = '0;
    case (win)
      2'd0: begin
        s = a >> 8;
        sp = (a[7:6] == 2'd2) ? 2'd1 : (a[7:6] == 2'd3) ? 2'd2 : 2'd0;
        off = (sp == 2'd0) ? 23'(a & 25'h7F) : 23'(a & 25'h3F);
      end
      2'd1: begin s = a >> 23; off = a[22:0]; end
      2'd2: begin s = a >> 22; off = 23'(a & 25'h3FFFFF); ok = !half; end
      default: ok = 0;
    endcase
    hit = ok && (s < 4) && slotPresent[s[1:0]];
    raw = modelData(int'(s[1:0]), sp, off);
    if (!hit) expR = 16'h0;
    else if (big && half) expR = {raw[7:0], raw[15:8]};
    else if (win == 2'd2) expR = {8'h00, raw[7:0]};
    else expR = raw;
    expW = (big && half) ? {wd[7:0], wd[15:8]} : wd;

    @(negedge clk);
    reqValid = 1'b1; reqWindow = win; reqAddr = addr; reqHalf = half;
    reqWrite = wr; reqWData = wd;
    #1;
    check({tag, " R9 strobe"}, 32'(modStrobe), hit ? 32'(1 << s[1:0]) : 32'h0);
    if (hit) begin
      check({tag, " space"}, 32'(modSpace), 32'(sp));
      check({tag, " offset"}, 32'(modOffset), 32'(off));
      check({tag, " R9 write flag"}, 32'(modWrite), 32'(wr));
      check({tag, " R9 size flag"}, 32'(modHalf), 32'(half));
      if (wr) check({tag, " wdata"}, 32'(modWData), 32'(expW));
    end
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    check({tag, " R9 strobe drops"}, 32'(modStrobe), 32'h0);
    check({tag, " R10 rspValid"}, 32'(rspValid), wr ? 32'h0 : 32'h1);
    if (!wr) check({tag, " rdata"}, 32'(rspData), 32'(expR));
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 rspValid", 32'(rspValid), 32'h0);
    check("R1 strobe", 32'(modStrobe), 32'h0);
    cfgRd(7'h2B, 8'h00, "R1 endian reg");
    cfgRd(7'h2F, 8'h00, "R1 endian io");
    cfgRd(7'h33, 8'h00, "R1 endian mem");

    // R7 configuration space
    cfgWr(7'h2F, 8'hFF);
    cfgRd(7'h2F, 8'h01, "R7 endian io set");
    cfgWr(7'h2B, 8'h03);
    cfgRd(7'h2B, 8'h01, "R7 endian reg set");
    cfgWr(7'h10, 8'h77);
    cfgRd(7'h10, 8'h00, "R7 other byte ignores write");
    cfgWr(7'h2C, 8'h00);
    cfgRd(7'h2F, 8'h01, "R7 neighbour write ignored");
    cfgRd(7'h33, 8'h00, "R7 mem bit untouched");
    cfgWr(7'h2F, 8'h00);
    cfgWr(7'h2B, 8'h00);

    // R2 small window, every space code
    access(2'd0, 25'h105, 0, 0, 16'h0, "R2 io code0");
    access(2'd0, 25'h27F, 0, 0, 16'h0, "R2 io code1");
    access(2'd0, 25'h0AA, 1, 0, 16'h0, "R2 id");
    access(2'd0, 25'h3C2, 1, 1, 16'h1234, "R2 int write");
    access(2'd0, 25'h400, 0, 0, 16'h0, "R2 slot4 miss");

    // R3 16-bit memory window
    access(2'd1, 25'h1ABCDEF, 1, 0, 16'h0, "R3 slot3 read");
    access(2'd1, 25'h0800002, 1, 1, 16'hA55A, "R3 slot1 write");

    // R4 8-bit memory window
    access(2'd2, 25'h0812345, 0, 0, 16'h0, "R4 slot2 byte");
    access(2'd2, 25'h0812345, 1, 0, 16'h0, "R4 halfword refused");
    access(2'd2, 25'h1400000, 0, 0, 16'h0, "R4 slot5 miss");

    // R5 / R6 big-endian small window and memory window
    cfgWr(7'h2F, 8'h01);
    access(2'd0, 25'h140, 0, 0, 16'h0, "R5 byte flip io");
    access(2'd0, 25'h0C1, 0, 1, 16'h00EE, "R5 byte flip int");
    access(2'd0, 25'h202, 1, 0, 16'h0, "R6 half swap io read");
    cfgWr(7'h33, 8'h01);
    access(2'd1, 25'h0000011, 0, 0, 16'h0, "R5 byte flip mem");
    access(2'd1, 25'h0900010, 1, 1, 16'hBEEF, "R6 half swap mem write");
    access(2'd1, 25'h1000020, 1, 0, 16'h0, "R6 half swap mem read");
    access(2'd2, 25'h0000003, 0, 0, 16'h0, "R4 no endian on 8-bit");
    cfgWr(7'h2F, 8'h00);
    cfgWr(7'h33, 8'h00);

    // R8 absent slots and no window
    slotPresent = 4'b1010;
    access(2'd1, 25'h0000100, 1, 0, 16'h0, "R8 absent read");
    access(2'd0, 25'h203, 0, 1, 16'h5555, "R8 absent write");
    access(2'd3, 25'h0000000, 0, 0, 16'h0, "R8 window3");
    slotPresent = 4'hF;

    // Mixed random traffic
    void'($urandom(32'h1F2E3D4C));
    for (int n = 0; n < 400; n++) begin
      logic [1:0] w;
      logic [24:0] ad;
      w = 2'($urandom % 4);
      ad = 25'($urandom);
      if (w == 2'd0) ad = 25'($urandom % 1280);
      if (n % 40 == 0) cfgWr(($urandom % 2) ? 7'h2F : 7'h33, 8'($urandom));
      if (n % 25 == 0) slotPresent = 4'($urandom);
      access(w, ad, bit'($urandom % 2), bit'($urandom % 2), 16'($urandom),
             (w == 2'd0) ? "R2 rand" : (w == 2'd1) ? "R3 rand" :
             (w == 2'd2) ? "R4 rand" : "R8 rand");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule